// File: doc/BRIEF.md
# Radio power-up and transmit sequencer

This block is the control state machine that sits between a packet-level game or network engine and the SPI command framer of a 2.4 GHz packet radio. Out of reset it powers the radio in a fixed order: it raises the regulator enable, pulses the active-low radio reset, waits a settling time in milliseconds, and switches on the crystal oscillator. It then polls the oscillator until it runs, writes the channel, address-filter and receive-threshold registers, and puts the radio into receive.

After power-up the engine gives commands with a channel number. A transmit command first retunes the radio if the channel differs from the current one. It then has the framer load the transmit FIFO and waits for the clear-channel pin. Next it issues the transmit strobe and times completion from a rising edge of the start-of-frame pin. A retune-only command runs the retune part by itself. Each register access or strobe goes out as one request on a valid/ack port. The framer serialises it and returns the status byte that the radio sent back.

Top module: `radio_seq`

## Requirements
- R1: While `rst_n` is low, `vreg_en`=0, `rf_rst_n`=1, `ready`=0, `done`=0 and `req_valid`=0.
- R2: `vreg_en` goes high in the first cycle after reset and then stays high. `rf_rst_n` goes low after VREG_CYC cycles and stays low for RST_CYC cycles. Then CLK_KHZ*SETTLE_MS cycles pass with no request.
- R3: The first request is a strobe (kind 0) to address 0x01. It is followed back to back by no-op strobes to address 0x00. These repeat until a no-op completes with `resp_status[OSC_BIT]`=1.
- R4: Configuration then issues register writes (kind 1) in this order. First 0x18 with data {FS_UPPER, CHAN_BASE+CHAN_STEP*channel in bits 9:0}. Next 0x11 with MDM_CFG and bit 11 forced to 0. Then, when THRESH_EN=1, 0x1C with data {THR_UPPER, THRESH in bits 6:0}.
- R5: Power-up ends with a strobe to 0x03. `ready` first reads high in the (RXS+1)-th cycle after the cycle in which that strobe's `req_ack` was high. RXS is ceil(CLK_KHZ*128/1000) cycles, at least 1, which equals 8 symbol periods of 16 us.
- R6: A transmit issues a FIFO-load request (kind 2, address 0x3E, data 0). It then waits until the synchronised `cca_pin` is high before it issues the transmit strobe to 0x04. No 0x04 strobe is issued while `cca_pin` is low.
- R7: After the 0x04 strobe, `done` pulses for one cycle in the (HOLD+3)-th cycle after `sfd_pin` rises, where HOLD = max(TX_HOLD, 60). `ready` is high in the following cycle. No request is made between the transmit strobe and `done`.
- R8: When a transmit names a channel other than the current one, it is preceded by the retune steps: strobe 0x06, the 0x18 channel write and strobe 0x03. The load request then appears in the (RXS+1)-th cycle after that 0x03 strobe's ack.
- R9: A retune-only command (`cmd_retune`=1) issues strobe 0x06, the 0x18 write and strobe 0x03. It pulses `done` in the (RXS+1)-th cycle after the 0x03 ack. A later transmit on that channel skips the retune.
- R10: `cmd_valid` is ignored in every cycle where `ready` is low.
- R11: `req_kind`, `req_addr` and `req_data` stay stable while `req_valid` is high and `req_ack` is low. A new request may start in the cycle after an ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from the engine, taken only when `ready` |
| cmd_retune | input | 1 | 1 = retune only, 0 = transmit |
| cmd_chan | input | CHAN_W | Channel number for the command |
| ready | output | 1 | Idle and able to take a command |
| done | output | 1 | One-cycle pulse when a command finishes |
| vreg_en | output | 1 | Radio regulator enable |
| rf_rst_n | output | 1 | Active-low radio reset pin |
| cca_pin | input | 1 | Clear-channel status pin (asynchronous) |
| sfd_pin | input | 1 | Start-of-frame status pin (asynchronous) |
| req_valid | output | 1 | Framer request pending |
| req_kind | output | 2 | 0 strobe, 1 register write, 2 TX FIFO load |
| req_addr | output | 6 | Radio register or strobe address |
| req_data | output | 16 | Write data, 0 otherwise |
| req_ack | input | 1 | Framer has finished the request (one cycle) |
| resp_status | input | 8 | Status byte returned with `req_ack` |

## Verification
The bench makes the oscillator poll fail twice. A sequencer that does not re-poll would write configuration to a radio whose oscillator is still stopped. The bench holds the clear-channel pin low for many cycles after the FIFO load, which exposes a design that strobes transmit into a busy channel. It also measures the exact cycle counts from the receive-on ack to the next step and from the start-of-frame edge to `done`, so a short settle or hold window shows up as a timing mismatch. Commands are pulsed while the block is busy and a channel change is followed by a transmit on the same channel: a design that loses track of the current channel would retune again or not at all, and the scoreboard would see unexpected or missing requests.

// File: rtl/radio_seq_pkg.sv
// Shared types for the radio sequencer: state codes, framer request kinds
// and radio register / strobe addresses used by the request encoder.
package radio_seq_pkg;

    typedef enum logic [4:0] {
        ST_PWR, ST_VREG, ST_RSTP, ST_SETTLE, ST_XOSC, ST_POLL,
        ST_CHAN, ST_MDM, ST_THR, ST_RXON, ST_RXWAIT, ST_IDLE,
        ST_RFOFF, ST_LOAD, ST_CCA, ST_TXON, ST_SFD, ST_HOLD, ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        RK_STROBE = 2'd0,
        RK_WRITE  = 2'd1,
        RK_LOAD   = 2'd2
    } req_kind_t;

    localparam logic [5:0] A_NOP    = 6'h00;
    localparam logic [5:0] A_XOSC   = 6'h01;
    localparam logic [5:0] A_RXON   = 6'h03;
    localparam logic [5:0] A_TXON   = 6'h04;
    localparam logic [5:0] A_RFOFF  = 6'h06;
    localparam logic [5:0] A_MDM    = 6'h11;
    localparam logic [5:0] A_CHAN   = 6'h18;
    localparam logic [5:0] A_THR    = 6'h1C;
    localparam logic [5:0] A_TXFIFO = 6'h3E;

endpackage

// File: rtl/rs_wait_timer.sv
// Shared wait counter. Counts while run is high; hit marks the last cycle of
// a window of 'limit' cycles and the count restarts, so back-to-back wait
// states each get a full window. Assumes limit >= 1.
module rs_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] count;

    assign hit = run && (count == limit - W'(1));

    // advance the window counter, clearing on idle or window end
    always_ff @(posedge clk) begin
        if (!rst_n || !run || hit) count <= '0;
        else                       count <= count + W'(1);
    end
endmodule

// File: rtl/rs_pin_sync.sv
// Two-flop synchroniser for N asynchronous status pins. Assumes each pin
// holds a level for at least two clock cycles.
module rs_pin_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;
        // two-stage capture of pin i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= pin[i];
                s2 <= s1;
            end
        end
        assign lvl[i] = s2;
    end
endmodule

// File: rtl/rs_req_encoder.sv
// Maps the sequencer state to a framer request: kind, radio address and
// 16-bit write data. Combinational; assumes the state holds until req_ack.
module rs_req_encoder
    import radio_seq_pkg::*;
#(
    parameter int          CHAN_W    = 4,
    parameter logic [5:0]  FS_UPPER  = 6'h10,
    parameter int          CHAN_BASE = 357,
    parameter int          CHAN_STEP = 5,
    parameter logic [15:0] MDM_CFG   = 16'h0AE2,
    parameter logic [8:0]  THR_UPPER = 9'h000,
    parameter logic [6:0]  THRESH    = 7'd64
) (
    input  seq_state_t        st,
    input  logic [CHAN_W-1:0] chan,
    output logic              valid,
    output req_kind_t         kind,
    output logic [5:0]        addr,
    output logic [15:0]       data
);
    localparam logic [15:0] ADDR_FILT_OFF = 16'h0800;

    logic [9:0] chan_fld;
    assign chan_fld = 10'(CHAN_BASE) + 10'(CHAN_STEP) * 10'(chan);

    // decode the request implied by the current state
    always_comb begin
        valid = 1'b1;
        kind  = RK_STROBE;
        addr  = A_NOP;
        data  = 16'h0000;
        unique case (st)
            ST_XOSC:  addr = A_XOSC;
            ST_POLL:  addr = A_NOP;
            ST_RXON:  addr = A_RXON;
            ST_RFOFF: addr = A_RFOFF;
            ST_TXON:  addr = A_TXON;
            ST_CHAN: begin
                kind = RK_WRITE;
                addr = A_CHAN;
                data = {FS_UPPER, chan_fld};
            end
            ST_MDM: begin
                kind = RK_WRITE;
                addr = A_MDM;
                data = MDM_CFG & ~ADDR_FILT_OFF;
            end
            ST_THR: begin
                kind = RK_WRITE;
                addr = A_THR;
                data = {THR_UPPER, THRESH};
            end
            ST_LOAD: begin
                kind = RK_LOAD;
                addr = A_TXFIFO;
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/radio_seq.sv
// Radio power-up, retune and transmit sequencer. Drives regulator enable and
// radio reset, issues strobes / writes through a valid-ack framer port and
// times transmit completion from the start-of-frame pin. Assumes the framer
// performs the FIFO load itself and returns the status byte with req_ack.
module radio_seq
    import radio_seq_pkg::*;
#(
    parameter int          CLK_KHZ   = 25000,
    parameter int          SETTLE_MS = 2,
    parameter int          VREG_CYC  = 16,
    parameter int          RST_CYC   = 8,
    parameter int          TX_HOLD   = 64,
    parameter int          CHAN_W    = 4,
    parameter int          INIT_CHAN = 0,
    parameter logic [5:0]  FS_UPPER  = 6'h10,
    parameter int          CHAN_BASE = 357,
    parameter int          CHAN_STEP = 5,
    parameter logic [15:0] MDM_CFG   = 16'h0AE2,
    parameter bit          THRESH_EN = 1'b1,
    parameter logic [8:0]  THR_UPPER = 9'h000,
    parameter logic [6:0]  THRESH    = 7'd64,
    parameter int          OSC_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_retune,
    input  logic [CHAN_W-1:0] cmd_chan,
    output logic              ready,
    output logic              done,
    output logic              vreg_en,
    output logic              rf_rst_n,
    input  logic              cca_pin,
    input  logic              sfd_pin,
    output logic              req_valid,
    output logic [1:0]        req_kind,
    output logic [5:0]        req_addr,
    output logic [15:0]       req_data,
    input  logic              req_ack,
    input  logic [7:0]        resp_status
);
    localparam int SETTLE_CYC = CLK_KHZ * SETTLE_MS;
    localparam int RXS_RAW    = (CLK_KHZ * 128 + 999) / 1000;
    localparam int RXS_CYC    = (RXS_RAW < 1) ? 1 : RXS_RAW;
    localparam int HOLD_CYC   = (TX_HOLD < 60) ? 60 : TX_HOLD;
    localparam int MAX_A      = (SETTLE_CYC > RXS_CYC) ? SETTLE_CYC : RXS_CYC;
    localparam int MAX_B      = (HOLD_CYC > VREG_CYC) ? HOLD_CYC : VREG_CYC;
    localparam int MAX_C      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC    = (MAX_C > RST_CYC) ? MAX_C : RST_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    seq_state_t        st, st_nxt;
    logic              in_init, is_tx;
    logic [CHAN_W-1:0] tgt_chan, cur_chan;
    logic [1:0]        pin_lvl;
    logic              cca_ok, sfd_lvl, sfd_prev, sfd_rise;
    logic              t_run, t_hit;
    logic [CNT_W-1:0]  t_lim;
    logic              osc_up, take_cmd;
    req_kind_t         enc_kind;
    logic              unused_status_bits;

    assign unused_status_bits = ^resp_status;
    assign osc_up   = resp_status[OSC_BIT];
    assign ready    = (st == ST_IDLE);
    assign done     = (st == ST_DONE);
    assign vreg_en  = (st != ST_PWR);
    assign rf_rst_n = (st != ST_RSTP);
    assign take_cmd = ready && cmd_valid;
    assign req_kind = enc_kind;

    rs_pin_sync #(.N(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({sfd_pin, cca_pin}),
        .lvl   (pin_lvl)
    );
    assign cca_ok  = pin_lvl[0];
    assign sfd_lvl = pin_lvl[1];

    // remember the previous synchronised start-of-frame level
    always_ff @(posedge clk) begin
        if (!rst_n) sfd_prev <= 1'b0;
        else        sfd_prev <= sfd_lvl;
    end
    assign sfd_rise = sfd_lvl && !sfd_prev;

    // pick the window length for the current wait state
    always_comb begin
        t_run = 1'b1;
        t_lim = CNT_W'(1);
        unique case (st)
            ST_VREG:   t_lim = CNT_W'(VREG_CYC);
            ST_RSTP:   t_lim = CNT_W'(RST_CYC);
            ST_SETTLE: t_lim = CNT_W'(SETTLE_CYC);
            ST_RXWAIT: t_lim = CNT_W'(RXS_CYC);
            ST_HOLD:   t_lim = CNT_W'(HOLD_CYC);
            default:   t_run = 1'b0;
        endcase
    end

    rs_wait_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t_run),
        .limit (t_lim),
        .hit   (t_hit)
    );

    rs_req_encoder #(
        .CHAN_W    (CHAN_W),
        .FS_UPPER  (FS_UPPER),
        .CHAN_BASE (CHAN_BASE),
        .CHAN_STEP (CHAN_STEP),
        .MDM_CFG   (MDM_CFG),
        .THR_UPPER (THR_UPPER),
        .THRESH    (THRESH)
    ) u_enc (
        .st    (st),
        .chan  (tgt_chan),
        .valid (req_valid),
        .kind  (enc_kind),
        .addr  (req_addr),
        .data  (req_data)
    );

    // next-state decision for the sequencer
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_PWR:    st_nxt = ST_VREG;
            ST_VREG:   if (t_hit) st_nxt = ST_RSTP;
            ST_RSTP:   if (t_hit) st_nxt = ST_SETTLE;
            ST_SETTLE: if (t_hit) st_nxt = ST_XOSC;
            ST_XOSC:   if (req_ack) st_nxt = ST_POLL;
            ST_POLL:   if (req_ack && osc_up) st_nxt = ST_CHAN;
            ST_CHAN:   if (req_ack) st_nxt = in_init ? ST_MDM : ST_RXON;
            ST_MDM:    if (req_ack) st_nxt = THRESH_EN ? ST_THR : ST_RXON;
            ST_THR:    if (req_ack) st_nxt = ST_RXON;
            ST_RXON:   if (req_ack) st_nxt = ST_RXWAIT;
            ST_RXWAIT: if (t_hit)
                           st_nxt = in_init ? ST_IDLE : (is_tx ? ST_LOAD : ST_DONE);
            ST_IDLE:   if (cmd_valid)
                           st_nxt = (cmd_retune || cmd_chan != cur_chan) ? ST_RFOFF : ST_LOAD;
            ST_RFOFF:  if (req_ack) st_nxt = ST_CHAN;
            ST_LOAD:   if (req_ack) st_nxt = ST_CCA;
            ST_CCA:    if (cca_ok) st_nxt = ST_TXON;
            ST_TXON:   if (req_ack) st_nxt = ST_SFD;
            ST_SFD:    if (sfd_rise) st_nxt = ST_HOLD;
            ST_HOLD:   if (t_hit) st_nxt = ST_DONE;
            ST_DONE:   st_nxt = ST_IDLE;
            default:   st_nxt = ST_PWR;
        endcase
    end

    // state register and command / channel bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_PWR;
            in_init  <= 1'b1;
            is_tx    <= 1'b0;
            tgt_chan <= CHAN_W'(INIT_CHAN);
            cur_chan <= CHAN_W'(INIT_CHAN);
        end else begin
            st <= st_nxt;
            if (take_cmd) begin
                tgt_chan <= cmd_chan;
                is_tx    <= !cmd_retune;
            end
            if (st == ST_CHAN && req_ack) cur_chan <= tgt_chan;
            if (st == ST_RXWAIT && t_hit) in_init <= 1'b0;
        end
    end
endmodule

// File: rtl/radio_seq_chk.sv
// Protocol checker for radio_seq, attached to every instance by bind.
module radio_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        vreg_en,
    input logic        rf_rst_n,
    input logic        ready,
    input logic        done,
    input logic        req_valid,
    input logic        req_ack,
    input logic [1:0]  req_kind,
    input logic [5:0]  req_addr,
    input logic [15:0] req_data
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_kind)
                                     && $stable(req_addr) && $stable(req_data)));

    // R2
    vreg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_en |=> vreg_en);

    // R2
    rst_under_vreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_rst_n |-> vreg_en);

    // R3
    req_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (vreg_en && rf_rst_n));

    // R4
    addr_filter_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1 && req_addr == 6'h11) |-> !req_data[11]);

    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ready && !req_valid));

    // R7
    done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
endmodule

bind radio_seq radio_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vreg_en   (vreg_en),
    .rf_rst_n  (rf_rst_n),
    .ready     (ready),
    .done      (done),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_data  (req_data)
);

// File: tb/radio_seq_tb.sv
// Scoreboard bench: tasks push expected framer requests, the framer model
// pops and compares each request as the sequencer issues it.
module radio_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 20;
    localparam int SETTLE_MS  = 2;
    localparam int VREG_CYC   = 4;
    localparam int RST_CYC    = 3;
    localparam int TX_HOLD    = 64;
    localparam int INIT_CHAN  = 3;
    localparam int OSC_BIT    = 6;
    localparam int FAIL_POLLS = 2;
    localparam int SETTLE_EXP = CLK_KHZ * SETTLE_MS;
    localparam int RXS_EXP    = 3;   // ceil(20*128/1000)
    localparam logic [15:0] MDM_IN  = 16'h0AE2;
    localparam logic [15:0] MDM_EXP = 16'h02E2;
    localparam logic [6:0]  THR_VAL = 7'd16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_retune = 1'b0;
    logic [3:0]  cmd_chan = 4'd0;
    logic        ready, done, vreg_en, rf_rst_n;
    logic        cca_pin = 1'b0, sfd_pin = 1'b0;
    logic        req_valid, req_ack = 1'b0;
    logic [1:0]  req_kind;
    logic [5:0]  req_addr;
    logic [15:0] req_data;
    logic [7:0]  resp_status = 8'h00;

    radio_seq #(
        .CLK_KHZ(CLK_KHZ), .SETTLE_MS(SETTLE_MS), .VREG_CYC(VREG_CYC),
        .RST_CYC(RST_CYC), .TX_HOLD(TX_HOLD), .CHAN_W(4), .INIT_CHAN(INIT_CHAN),
        .FS_UPPER(6'h10), .CHAN_BASE(357), .CHAN_STEP(5), .MDM_CFG(MDM_IN),
        .THRESH_EN(1'b1), .THR_UPPER(9'h000), .THRESH(THR_VAL), .OSC_BIT(OSC_BIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_retune(cmd_retune),
        .cmd_chan(cmd_chan), .ready(ready), .done(done), .vreg_en(vreg_en),
        .rf_rst_n(rf_rst_n), .cca_pin(cca_pin), .sfd_pin(sfd_pin),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_data(req_data), .req_ack(req_ack), .resp_status(resp_status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, last_ack = 0, polls = 0, done_cnt = 0;
    bit finished = 1'b0;
    logic [1:0]  q_kind[$];
    logic [5:0]  q_addr[$];
    logic [15:0] q_data[$];
    int          q_gap[$];
    string       q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_req(input logic [1:0] k, input logic [5:0] a,
                              input logic [15:0] d, input int gap, input string tag);
        q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d);
        q_gap.push_back(gap); q_tag.push_back(tag);
    endtask

    function automatic logic [15:0] chan_word(input int c);
        return {6'h10, 10'(357 + 5 * c)};
    endfunction

    // framer model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            req_ack = 1'b0;
            if (rst_n && req_valid) begin
                automatic logic [1:0]  k = req_kind;
                automatic logic [5:0]  a = req_addr;
                automatic logic [15:0] d = req_data;
                automatic int arr = cyc;
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R10", "unexpected request addr", longint'(a), 0);
                end else begin
                    automatic logic [1:0]  ek = q_kind.pop_front();
                    automatic logic [5:0]  ea = q_addr.pop_front();
                    automatic logic [15:0] ed = q_data.pop_front();
                    automatic int          eg = q_gap.pop_front();
                    automatic string       tg = q_tag.pop_front();
                    chk(k == ek && a == ea && d == ed, tg, "request {kind,addr,data}",
                        longint'({k, a, d}), longint'({ek, ea, ed}));
                    if (eg >= 0)
                        chk(arr - last_ack == eg, tg, "cycles from previous ack",
                            longint'(arr - last_ack), longint'(eg));
                end
                if (k == 2'd0 && a == 6'h04)
                    chk(cca_pin == 1'b1, "R6", "transmit strobe with clear-channel", cca_pin, 1);
                if (k == 2'd0 && a == 6'h00) polls++;
                repeat (2) @(negedge clk);
                resp_status = (k == 2'd0 && a == 6'h00 && polls > FAIL_POLLS) ? 8'h40 : 8'h00;
                req_ack = 1'b1;
                last_ack = cyc;
            end
        end
    end

    task automatic wait_empty();
        while (q_addr.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic send_cmd(input bit retune, input int ch);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_retune = retune; cmd_chan = 4'(ch);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // raise start-of-frame and measure cycles to done
    task automatic sfd_and_done(input string rq, input int exp_dc);
        automatic int k = 0;
        @(negedge clk);
        sfd_pin = 1'b1;
        do begin
            @(negedge clk);
            k++;
        end while (!done && k < 500);
        chk(k == TX_HOLD + 3, rq, "cycles from start-of-frame to done", k, TX_HOLD + 3);
        @(negedge clk);
        chk(ready == 1'b1, "R7", "ready after done", ready, 1);
        chk(done_cnt == exp_dc, rq, "done pulse count", done_cnt, exp_dc);
        sfd_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        automatic int n;
        repeat (4) @(negedge clk);
        chk(!vreg_en && rf_rst_n && !ready && !done && !req_valid, "R1", "reset outputs",
            {vreg_en, rf_rst_n, ready, done, req_valid}, 5'b01000);

        // power-up scoreboard: oscillator on, three polls, config, receive-on
        expect_req(2'd0, 6'h01, 16'h0, -1, "R3");
        expect_req(2'd0, 6'h00, 16'h0, 1, "R3");
        expect_req(2'd0, 6'h00, 16'h0, 1, "R3");
        expect_req(2'd0, 6'h00, 16'h0, 1, "R3");
        expect_req(2'd1, 6'h18, chan_word(INIT_CHAN), 1, "R4");
        expect_req(2'd1, 6'h11, MDM_EXP, 1, "R4");
        expect_req(2'd1, 6'h1C, {9'h000, THR_VAL}, 1, "R4");
        expect_req(2'd0, 6'h03, 16'h0, 1, "R5");

        rst_n = 1'b1;
        @(negedge clk);
        chk(vreg_en == 1'b1, "R2", "regulator enable after reset", vreg_en, 1);
        n = 0;
        while (rf_rst_n) begin n++; @(negedge clk); end
        chk(n == VREG_CYC, "R2", "cycles before reset pulse", n, VREG_CYC);
        n = 0;
        while (!rf_rst_n) begin n++; @(negedge clk); end
        chk(n == RST_CYC, "R2", "reset pulse width", n, RST_CYC);
        n = 0;
        while (!req_valid) begin
            n++;
            cmd_valid = (n == 5);   // R10: command while not ready
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(n == SETTLE_EXP, "R2", "settle cycles before first request", n, SETTLE_EXP);

        while (!ready) @(negedge clk);
        chk(cyc == last_ack + 1 + RXS_EXP, "R5", "ready after receive-on ack",
            cyc - last_ack, 1 + RXS_EXP);
        chk(q_addr.size() == 0 && polls == 3, "R3", "all power-up requests seen, polls",
            polls, 3);
        chk(done_cnt == 0, "R10", "no done from command while busy", done_cnt, 0);

        // transmit on the current channel with a busy channel at first
        expect_req(2'd2, 6'h3E, 16'h0, -1, "R6");
        expect_req(2'd0, 6'h04, 16'h0, -1, "R6");
        send_cmd(1'b0, INIT_CHAN);
        while (q_addr.size() != 1) @(negedge clk);
        repeat (10) @(negedge clk);
        cmd_valid = 1'b1; cmd_retune = 1'b1; cmd_chan = 4'd9;   // R10: ignored while busy
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(q_addr.size() == 1, "R6", "transmit strobe held while channel busy",
            q_addr.size(), 1);
        cca_pin = 1'b1;
        wait_empty();
        chk(!req_valid, "R7", "no request while waiting for start-of-frame", req_valid, 0);
        sfd_and_done("R7", 1);

        // transmit on a new channel: retune first
        expect_req(2'd0, 6'h06, 16'h0, -1, "R8");
        expect_req(2'd1, 6'h18, chan_word(9), 1, "R8");
        expect_req(2'd0, 6'h03, 16'h0, 1, "R8");
        expect_req(2'd2, 6'h3E, 16'h0, 1 + RXS_EXP, "R8");
        expect_req(2'd0, 6'h04, 16'h0, -1, "R8");
        send_cmd(1'b0, 9);
        wait_empty();
        sfd_and_done("R8", 2);

        // retune only
        expect_req(2'd0, 6'h06, 16'h0, -1, "R9");
        expect_req(2'd1, 6'h18, chan_word(12), 1, "R9");
        expect_req(2'd0, 6'h03, 16'h0, 1, "R9");
        send_cmd(1'b1, 12);
        while (!done) @(negedge clk);
        chk(cyc == last_ack + 1 + RXS_EXP, "R9", "done after receive-on ack",
            cyc - last_ack, 1 + RXS_EXP);
        @(negedge clk);
        chk(ready && q_addr.size() == 0, "R9", "idle after retune", ready, 1);

        // transmit on the retuned channel: no retune expected
        expect_req(2'd2, 6'h3E, 16'h0, -1, "R9");
        expect_req(2'd0, 6'h04, 16'h0, -1, "R9");
        send_cmd(1'b0, 12);
        wait_empty();
        sfd_and_done("R9", 4);

        repeat (30) @(negedge clk);
        chk(q_addr.size() == 0 && done_cnt == 4 && ready, "R10", "quiet when idle",
            done_cnt, 4);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule